// File: doc/BRIEF.md
# Timestamp Record FIFO with Word-Serial Readout

This block buffers the timestamp records captured for PTP event messages on one direction (transmit or receive) of one network port. The capture logic hands over a complete record in a single cycle: a 16-bit tag, 48 bits of seconds, 32 bits of nanoseconds, a 64-bit clock identity, a 16-bit port number and a 16-bit sequence id. The host then drains each record through one 16-bit data register, word by word.

A status register exposes the capture enable, the position of the next word within the current record, and a saturating count of records lost to a full FIFO. The block also drives a not-empty flag into its own bit of a buffer-status vector that several such instances share. Parameters select the port index and the direction, and with them the bit that the block owns. The FIFO depth is a parameter: a deployed port needs room for 90 records, while simulation uses a smaller default.

Top module: `tsrec_fifo`

## Requirements
- R1: After reset the status word reads 0, which means capture is disabled, the read position is 0 and the discard count is 0. The not-empty vector and the data word also read 0.
- R2: While the enable bit (status bit 15) is 0, a record presented on the capture side is not stored.
- R3: A record is read as 12 words: tag, seconds (3 words), nanoseconds (2 words), clock identity (4 words), port number, sequence id. Each multi-word field is returned most significant word first. The data word shows the current word in the same cycle as the read strobe.
- R4: Status bits 12:8 hold the read position. It is 0 when the next word is a tag, and each read of a non-empty FIFO raises it by one.
- R5: The read of word 11 pops the record and returns the read position to 0. Records leave in the order they arrived.
- R6: A read while the FIFO is empty returns 0 and leaves the read position unchanged.
- R7: A capture that finds the FIFO full, with no pop in the same cycle, is dropped and increments the discard count in status bits 7:4. The count saturates at 15.
- R8: Writing 0 to the status register clears the discard count and the enable bit.
- R9: The not-empty flag appears only at bit IS_RX*N_PORTS+PORT_IDX of the not-empty vector. All other bits of the vector stay 0.
- R10: When the FIFO is full, a capture and a pop in the same cycle are both accepted. Nothing is discarded and the FIFO stays full.
- R11: A status write loads bit 15 into the enable. Status bits 14:13 and 3:0 read 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | Capture strobe for one full record |
| cap_tag | input | 16 | Tag; bits 2:0 give the event type (1 Sync, 2 Pdelay_Req, 3 Pdelay_Resp, 4 Delay_Req) |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clkid | input | 64 | Clock identity |
| cap_pnum | input | 16 | Port number |
| cap_seq | input | 16 | Sequence id |
| data_rd | input | 1 | Host read strobe for the data register |
| data_word | output | 16 | Current record word (0 when empty) |
| stat_wr | input | 1 | Host write strobe for the status register |
| stat_wdata | input | 16 | Status write data |
| stat_rdata | output | 16 | Status: enable, read position, discard count |
| nempty_vec | output | 2*N_PORTS | Buffer-status contribution, one bit owned |

## Verification
The data word depends only on the head record and the registered read position, so the bench compares it in the same cycle as the read strobe, before the edge that consumes the word. Every other result is a register: the read position, discard count, enable and not-empty flag change at the first rising edge after the stimulus. The bench therefore drives its inputs on the falling edge and checks those values on the falling edge that follows that one rising edge. The full-and-pop case is checked the same way, and then a drain counts the records that remain.

// File: rtl/tsrec_pkg.sv
package tsrec_pkg;
   localparam int WORD_W  = 16;
   localparam int TAG_W   = 16;
   localparam int SEC_W   = 48;
   localparam int NSEC_W  = 32;
   localparam int CLKID_W = 64;
   localparam int PNUM_W  = 16;
   localparam int SEQ_W   = 16;
   localparam int REC_W   = TAG_W + SEC_W + NSEC_W + CLKID_W + PNUM_W + SEQ_W;
   localparam int N_WORDS = REC_W / WORD_W;
   localparam int POS_W   = 5;
   localparam int DISC_W  = 4;

   // status register field positions (host-visible)
   localparam int ST_EN_BIT   = 15;
   localparam int ST_POS_LSB  = 8;
   localparam int ST_DISC_LSB = 4;

   // field order equals readout order, most significant first
   typedef struct packed {
      logic [TAG_W-1:0]   tag;
      logic [SEC_W-1:0]   sec;
      logic [NSEC_W-1:0]  nsec;
      logic [CLKID_W-1:0] clkid;
      logic [PNUM_W-1:0]  pnum;
      logic [SEQ_W-1:0]   seq;
   } tsrec_t;
endpackage

// File: rtl/tsrec_store.sv
module tsrec_store
   import tsrec_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   push,
   input  logic   pop,
   input  tsrec_t din,
   output tsrec_t head,
   output logic   empty,
   output logic   full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   tsrec_t mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic push_ok, pop_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == FULL_CNT);
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign head    = mem_q[rd_ptr_q];

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr_q + 1'b1;
         assign rd_nxt = rd_ptr_q + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
         assign rd_nxt = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wr_ptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_nxt;
         if (pop_ok)  rd_ptr_q <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/tsrec_seq.sv
module tsrec_seq
   import tsrec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              empty,
   input  tsrec_t            head,
   output logic [WORD_W-1:0] word,
   output logic [POS_W-1:0]  pos,
   output logic              pop
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_WORDS - 1);

   logic [REC_W-1:0]  flat;
   logic [WORD_W-1:0] words [N_WORDS];
   logic adv;

   assign flat = head;

   generate
      for (genvar k = 0; k < N_WORDS; k++) begin : g_slice
         assign words[k] = flat[REC_W-1-k*WORD_W -: WORD_W];
      end
   endgenerate

   assign adv  = rd && !empty;
   assign pop  = adv && (pos == LAST_POS);
   assign word = empty ? '0 : words[pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pos <= '0;
      else if (pop) pos <= '0;
      else if (adv) pos <= pos + 1'b1;
   end
endmodule

// File: rtl/tsrec_stat.sv
module tsrec_stat
   import tsrec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              drop,
   output logic              en,
   output logic [DISC_W-1:0] disc
);
   localparam logic [DISC_W-1:0] DISC_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         disc <= '0;
      end else begin
         if (wr) en <= wdata[ST_EN_BIT];
         if (wr && (wdata == '0))           disc <= '0;
         else if (drop && disc != DISC_MAX) disc <= disc + 1'b1;
      end
   end
endmodule

// File: rtl/tsrec_fifo.sv
module tsrec_fifo
   import tsrec_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int N_PORTS  = 3,
   parameter int PORT_IDX = 0,
   parameter int IS_RX    = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_valid,
   input  logic [TAG_W-1:0]     cap_tag,
   input  logic [SEC_W-1:0]     cap_sec,
   input  logic [NSEC_W-1:0]    cap_nsec,
   input  logic [CLKID_W-1:0]   cap_clkid,
   input  logic [PNUM_W-1:0]    cap_pnum,
   input  logic [SEQ_W-1:0]     cap_seq,
   input  logic                 data_rd,
   output logic [WORD_W-1:0]    data_word,
   input  logic                 stat_wr,
   input  logic [WORD_W-1:0]    stat_wdata,
   output logic [WORD_W-1:0]    stat_rdata,
   output logic [2*N_PORTS-1:0] nempty_vec
);
   localparam int NE_BIT = IS_RX * N_PORTS + PORT_IDX;

   generate
      if (DEPTH < 2 || DEPTH > 128) begin : g_bad_depth
         $error("tsrec_fifo: DEPTH must be within 2..128");
      end
      if (PORT_IDX < 0 || PORT_IDX >= N_PORTS) begin : g_bad_port
         $error("tsrec_fifo: PORT_IDX out of range");
      end
      if (IS_RX != 0 && IS_RX != 1) begin : g_bad_dir
         $error("tsrec_fifo: IS_RX must be 0 or 1");
      end
      if (N_WORDS >= (1 << POS_W)) begin : g_bad_pos
         $error("tsrec_fifo: read position field too narrow");
      end
   endgenerate

   tsrec_t cap_rec, head;
   logic empty, full, pop, push, drop, en;
   logic [POS_W-1:0]  pos;
   logic [DISC_W-1:0] disc;

   assign cap_rec = '{tag: cap_tag, sec: cap_sec, nsec: cap_nsec,
                      clkid: cap_clkid, pnum: cap_pnum, seq: cap_seq};
   assign push = cap_valid && en;
   assign drop = push && full && !pop;

   tsrec_store #(.DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .din   (cap_rec),
      .head  (head),
      .empty (empty),
      .full  (full)
   );

   tsrec_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (data_rd),
      .empty (empty),
      .head  (head),
      .word  (data_word),
      .pos   (pos),
      .pop   (pop)
   );

   tsrec_stat u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (stat_wr),
      .wdata (stat_wdata),
      .drop  (drop),
      .en    (en),
      .disc  (disc)
   );

   always_comb begin
      stat_rdata = '0;
      stat_rdata[ST_EN_BIT] = en;
      stat_rdata[ST_POS_LSB +: POS_W] = pos;
      stat_rdata[ST_DISC_LSB +: DISC_W] = disc;
   end

   generate
      for (genvar b = 0; b < 2*N_PORTS; b++) begin : g_ne
         if (b == NE_BIT) begin : g_own
            assign nempty_vec[b] = !empty;
         end else begin : g_other
            assign nempty_vec[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/tsrec_fifo_chk.sv
module tsrec_fifo_chk #(
   parameter int N_PORTS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 data_rd,
   input logic [15:0]          data_word,
   input logic                 stat_wr,
   input logic [15:0]          stat_wdata,
   input logic [15:0]          stat_rdata,
   input logic [2*N_PORTS-1:0] nempty_vec
);
   logic [4:0] pos;
   logic [3:0] disc;
   logic en, ne;
   assign pos  = stat_rdata[12:8];
   assign disc = stat_rdata[7:4];
   assign en   = stat_rdata[15];
   assign ne   = |nempty_vec;

   assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pos < 5'd12);
   assert_pos_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && ne && pos < 5'd11) |=> pos == 5'($past(pos) + 5'd1));
   assert_pop_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && ne && pos == 5'd11) |=> pos == 5'd0);
   assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ne |-> (pos == 5'd0 && data_word == 16'd0));
   assert_no_fill_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ne) |=> !ne);
   assert_disc_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (disc == 4'hF && !stat_wr) |=> disc == 4'hF);
   assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && stat_wdata == 16'd0) |=> (disc == 4'd0 && !en));
   assert_ne_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(nempty_vec));
   assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rdata[14:13] == 2'b00 && stat_rdata[3:0] == 4'h0);
endmodule

bind tsrec_fifo tsrec_fifo_chk #(.N_PORTS(N_PORTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .data_rd    (data_rd),
   .data_word  (data_word),
   .stat_wr    (stat_wr),
   .stat_wdata (stat_wdata),
   .stat_rdata (stat_rdata),
   .nempty_vec (nempty_vec)
);

// File: tb/tsrec_fifo_tb.sv
module tsrec_fifo_tb;
   localparam int DEPTH = 8;
   localparam int NP    = 3;
   localparam logic [5:0] NE_EXP = 6'b010000; // port 1, receive

   localparam logic [191:0] REC_TBL [4] = '{
      {16'h0001, 48'h0000_6543_2101, 32'h1234_5678, 64'h0011_2233_4455_6677, 16'h0001, 16'h0100},
      {16'h0002, 48'hFFFF_0000_8001, 32'h3B9A_C9FF, 64'hA5A5_5A5A_F00D_BEEF, 16'h0002, 16'hFFFE},
      {16'h0003, 48'h8000_0000_0000, 32'h0000_0001, 64'h8000_0000_0000_0001, 16'hFFFF, 16'h0000},
      {16'h0004, 48'h0000_0000_0001, 32'h8000_0000, 64'hFEDC_BA98_7654_3210, 16'h7FFF, 16'h1234}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cap_valid = 1'b0;
   logic [191:0] cap_rec = '0;
   logic data_rd = 1'b0;
   logic stat_wr = 1'b0;
   logic [15:0] stat_wdata = '0;
   logic [15:0] data_word, stat_rdata;
   logic [5:0] nempty_vec;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tsrec_fifo #(.DEPTH(DEPTH), .N_PORTS(NP), .PORT_IDX(1), .IS_RX(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid),
      .cap_tag(cap_rec[191:176]), .cap_sec(cap_rec[175:128]),
      .cap_nsec(cap_rec[127:96]), .cap_clkid(cap_rec[95:32]),
      .cap_pnum(cap_rec[31:16]), .cap_seq(cap_rec[15:0]),
      .data_rd(data_rd), .data_word(data_word),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
      .nempty_vec(nempty_vec)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push_rec(input logic [191:0] r);
      cap_rec = r; cap_valid = 1'b1;
      cyc();
      cap_valid = 1'b0;
   endtask

   task automatic rd_word(output logic [15:0] w);
      w = data_word;
      data_rd = 1'b1;
      cyc();
      data_rd = 1'b0;
   endtask

   task automatic wr_stat(input logic [15:0] v);
      stat_wdata = v; stat_wr = 1'b1;
      cyc();
      stat_wr = 1'b0;
   endtask

   function automatic logic [191:0] mk_rec(input int i);
      return {16'(i % 4 + 1), 48'h1000_0000_0000 + 48'(i), 32'(i * 7),
              64'hC0DE_0000_0000_0000 + 64'(i), 16'(i + 2), 16'(i)};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] w;
      logic [15:0] last_seq;
      logic [15:0] first_seq;
      int nrec;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 status", 32'(stat_rdata), 32'h0);
      chk("R1 nempty", 32'(nempty_vec), 32'h0);
      chk("R1 data", 32'(data_word), 32'h0);

      // R2: capture disabled
      push_rec(REC_TBL[0]);
      chk("R2 no capture while disabled", 32'(nempty_vec), 32'h0);

      // R6: empty read
      rd_word(w);
      chk("R6 empty read value", 32'(w), 32'h0);
      chk("R6 empty read keeps pos", 32'(stat_rdata[12:8]), 32'h0);

      // R11: enable
      wr_stat(16'h8000);
      chk("R11 enable readback", 32'(stat_rdata), 32'h8000);

      // table walk: R3, R4, R5, R9
      foreach (REC_TBL[i]) push_rec(REC_TBL[i]);
      chk("R9 nempty bit", 32'(nempty_vec), 32'(NE_EXP));
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 12; k++) begin
            chk($sformatf("R4 pos rec%0d word%0d", r, k), 32'(stat_rdata[12:8]), 32'(k));
            chk($sformatf("R3 word rec%0d word%0d", r, k), 32'(data_word),
                32'(REC_TBL[r][191-16*k -: 16]));
            rd_word(w);
         end
         chk($sformatf("R5 wrap after rec%0d", r), 32'(stat_rdata[12:8]), 32'h0);
      end
      chk("R5 empty after all pops", 32'(nempty_vec), 32'h0);

      // R7: overflow counting and saturation
      for (int i = 0; i < DEPTH; i++) push_rec(mk_rec(i));
      chk("R7 no discard when just full", 32'(stat_rdata[7:4]), 32'h0);
      for (int i = 0; i < 3; i++) push_rec(mk_rec(100 + i));
      chk("R7 discard count 3", 32'(stat_rdata[7:4]), 32'h3);
      for (int i = 0; i < 17; i++) push_rec(mk_rec(200 + i));
      chk("R7 discard saturates", 32'(stat_rdata[7:4]), 32'hF);
      chk("R9 still nonempty", 32'(nempty_vec), 32'(NE_EXP));

      // R8: zero write clears count and enable
      wr_stat(16'h0000);
      chk("R8 cleared status", 32'(stat_rdata), 32'h0);
      push_rec(mk_rec(300));
      chk("R8 disabled capture ignored", 32'(stat_rdata[7:4]), 32'h0);
      wr_stat(16'h8000);
      chk("R11 re-enabled", 32'(stat_rdata[15]), 32'h1);

      // R10: full, push and pop in the same cycle
      for (int k = 0; k < 11; k++) rd_word(w);
      chk("R10 pos before last word", 32'(stat_rdata[12:8]), 32'd11);
      cap_rec = mk_rec(0);
      cap_rec[15:0] = 16'hAAAA;
      cap_valid = 1'b1;
      data_rd = 1'b1;
      cyc();
      cap_valid = 1'b0;
      data_rd = 1'b0;
      chk("R10 no discard on full push+pop", 32'(stat_rdata[7:4]), 32'h0);
      chk("R10 pos wrapped", 32'(stat_rdata[12:8]), 32'h0);

      nrec = 0;
      first_seq = '1;
      last_seq = '0;
      while (nempty_vec != 6'b0 && nrec < 2*DEPTH) begin
         for (int k = 0; k < 12; k++) begin
            rd_word(w);
            if (k == 11) begin
               if (nrec == 0) first_seq = w;
               last_seq = w;
            end
         end
         nrec++;
      end
      chk("R10 fifo stayed full", 32'(nrec), 32'(DEPTH));
      chk("R5 fifo order first", 32'(first_seq), 32'h1);
      chk("R10 new record at tail", 32'(last_seq), 32'hAAAA);
      chk("R6 empty after drain", 32'(data_word), 32'h0);

      finish_run();
   end
endmodule